// File: doc/BRIEF.md
# Vectored Prioritized Interrupt Controller

This block collects interrupt requests from six sources (timer events, communication events and external request lines), holds each in a pending latch, and offers the CPU a single interrupt request. A source can win only when its mask bit is set and the global enable is on. When several enabled sources are pending, a 3-bit priority code picks the winner. Each code selects one fixed rotation of the six sources.

When the CPU accepts the interrupt, the block records the winning source and clears that source's pending bit. It also drops the global enable, so no further interrupt is taken until firmware turns it on again. The block then asks the CPU to save its context, using a request and done handshake. After that it reads the 16-bit handler address from the winner's two-byte vector slot through a simple memory read port. The CPU gets the address and the source number in a one-cycle valid pulse.

Firmware reaches the mask, pending, priority and enable registers through a small write port, and all four can be read at the outputs. While the CPU is halted, requests keep latching, and any enabled request raises a wake signal.

Top module: `vic_core`

## Requirements
- R1: After synchronous reset, all of the following are 0: pending, mask, priority code and global enable. The outputs irq_o, save_req_o, mem_rd_o and vec_valid_o are also low.
- R2: A rising edge on src_i[n] sets pending bit n. A line held high sets the bit only once. A control write with ctl_addr=1 replaces the pending bits with ctl_wdata[5:0]. If a rising edge arrives in the same cycle as that write, the edge still sets its bit.
- R3: irq_o is high exactly when the fetch unit is idle, global enable is 1, and at least one pending bit has its mask bit set. The mask is written with ctl_addr=0 from ctl_wdata[5:0], where bit n belongs to source n.
- R4: The priority code is written with ctl_addr=2 from ctl_wdata[2:0]. With a code k from 0 to 5, the winner is the first enabled source in the order k, k+1, ..., 5, 0, ..., k-1. Codes 6 and 7 use the order 0 to 5.
- R5: When ack_i is high while irq_o is high, the next cycle shows all of the following: global enable is 0, the winner's pending bit is cleared, and save_req_o is high. save_req_o stays high until save_done_i is sampled high. A grant overrides a same-cycle write of the enable. The enable is written with ctl_addr=3 from ctl_wdata[0].
- R6: After the save completes, mem_rd_o is high for two consecutive cycles, first with mem_addr_o = 2n and then with 2n+1, where n is the winner. mem_rdata_i carries the addressed byte one cycle after each read.
- R7: Two cycles after the second read, vec_valid_o pulses for one cycle. In that cycle vec_addr_o = {byte at 2n, byte at 2n+1} and vec_src_o = n.
- R8: A request that rises during the save or the vector fetch is latched in pending. irq_o stays low until the fetch sequence has returned to idle.
- R9: wake_o is high exactly when halt_i is high, global enable is 1, and some pending bit has its mask bit set. Requests keep latching while halt_i is high.
- R10: When irq_o is low, ack_i has no effect: no save request starts and the pending bits do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | 6 | Request lines, rising-edge sensitive |
| ctl_we | input | 1 | Control register write strobe |
| ctl_addr | input | 2 | Control register select: 0 mask, 1 pending, 2 priority, 3 enable |
| ctl_wdata | input | 8 | Control write data |
| ack_i | input | 1 | CPU accepts the interrupt cycle |
| save_done_i | input | 1 | CPU has finished its context save |
| halt_i | input | 1 | CPU is halted |
| irq_o | output | 1 | Interrupt request to the CPU |
| wake_o | output | 1 | Enabled request present while halted |
| save_req_o | output | 1 | Context save requested |
| mem_rd_o | output | 1 | Vector memory read strobe |
| mem_addr_o | output | 8 | Vector memory byte address |
| mem_rdata_i | input | 8 | Vector memory read data, one cycle after the read |
| vec_valid_o | output | 1 | Handler address valid pulse |
| vec_addr_o | output | 16 | Handler address |
| vec_src_o | output | 3 | Winning source number |
| mask_o | output | 6 | Mask register |
| pend_o | output | 6 | Pending register |
| prio_o | output | 3 | Priority code |
| gie_o | output | 1 | Global enable |

## Verification
The assertions check the following on every cycle:
- irq_o never rises without global enable and an enabled pending bit.
- A grant always drops the enable and starts the save on the next cycle, and a save request never starts without a grant.
- The odd vector read directly follows the even one, and every read address falls inside the six vector slots.
- vec_valid_o is a single-cycle pulse, and wake_o implies halt.

Other behaviours need the bench's scenarios, checked against its reference model: which source wins under each priority rotation, the exact handler bytes returned, edge detection on a held line, the collision between an edge and a pending write, and requests that latch during the fetch.

// File: rtl/vic_pkg.sv
package vic_pkg;

    localparam int NSRC  = 6;
    localparam int SRC_W = 3;

    typedef enum logic [2:0] {
        FS_IDLE,
        FS_SAVE,
        FS_RDHI,
        FS_RDLO,
        FS_WAIT,
        FS_DONE
    } fetch_state_e;

    typedef enum logic [1:0] {
        CA_MASK = 2'd0,
        CA_PEND = 2'd1,
        CA_PRIO = 2'd2,
        CA_GIE  = 2'd3
    } ctl_addr_e;

    typedef struct packed {
        logic             hit;
        logic [SRC_W-1:0] idx;
    } pick_t;

    // Rotated search: the code names the highest source, wrapping around.
    function automatic pick_t pick_winner(input logic [NSRC-1:0] req,
                                          input logic [SRC_W-1:0] code);
        pick_t r;
        int    base;
        int    idx;
        r    = '0;
        base = (int'(code) < NSRC) ? int'(code) : 0;
        for (int i = 0; i < NSRC; i++) begin
            idx = base + i;
            if (idx >= NSRC) idx = idx - NSRC;
            if (!r.hit && req[idx]) begin
                r.hit = 1'b1;
                r.idx = SRC_W'(idx);
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/vic_pending.sv
module vic_pending
    import vic_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [NSRC-1:0]  src_i,
    input  logic             wr_en,
    input  logic [NSRC-1:0]  wr_val,
    input  logic             clr_en,
    input  logic [SRC_W-1:0] clr_idx,
    output logic [NSRC-1:0]  pend_o
);
    logic [NSRC-1:0] src_q;
    logic [NSRC-1:0] pend_q;
    logic [NSRC-1:0] rise;
    logic [NSRC-1:0] clr_mask;
    logic [NSRC-1:0] base;

    always_comb begin
        rise = src_i & ~src_q;
        base = wr_en ? wr_val : pend_q;
    end

    for (genvar g = 0; g < NSRC; g++) begin : g_clr
        assign clr_mask[g] = clr_en && (int'(clr_idx) == g);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            src_q  <= '0;
            pend_q <= '0;
        end else begin
            src_q  <= src_i;
            pend_q <= (base & ~clr_mask) | rise;
        end
    end

    assign pend_o = pend_q;
endmodule

// File: rtl/vic_arbiter.sv
module vic_arbiter
    import vic_pkg::*;
(
    input  logic [NSRC-1:0]  req_i,
    input  logic [SRC_W-1:0] code_i,
    output logic             hit_o,
    output logic [SRC_W-1:0] idx_o
);
    pick_t pick;

    always_comb begin
        pick  = pick_winner(req_i, code_i);
        hit_o = pick.hit;
        idx_o = pick.idx;
    end
endmodule

// File: rtl/vic_fetch.sv
module vic_fetch
    import vic_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                grant_i,
    input  logic [SRC_W-1:0]    grant_idx_i,
    input  logic                save_done_i,
    output logic                idle_o,
    output logic                save_req_o,
    output logic                mem_rd_o,
    output logic [ADDR_W-1:0]   mem_addr_o,
    input  logic [DATA_W-1:0]   mem_rdata_i,
    output logic                vec_valid_o,
    output logic [2*DATA_W-1:0] vec_addr_o,
    output logic [SRC_W-1:0]    vec_src_o
);
    fetch_state_e               state_q;
    logic [SRC_W-1:0]           src_q;
    logic [2*DATA_W-1:0]        vec_q;
    logic                       lo_sel;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= FS_IDLE;
            src_q   <= '0;
            vec_q   <= '0;
        end else begin
            unique case (state_q)
                FS_IDLE: if (grant_i) begin
                    state_q <= FS_SAVE;
                    src_q   <= grant_idx_i;
                end
                FS_SAVE: if (save_done_i) state_q <= FS_RDHI;
                FS_RDHI: state_q <= FS_RDLO;
                FS_RDLO: begin
                    vec_q[2*DATA_W-1:DATA_W] <= mem_rdata_i;
                    state_q <= FS_WAIT;
                end
                FS_WAIT: begin
                    vec_q[DATA_W-1:0] <= mem_rdata_i;
                    state_q <= FS_DONE;
                end
                FS_DONE: state_q <= FS_IDLE;
                default: state_q <= FS_IDLE;
            endcase
        end
    end

    always_comb begin
        lo_sel      = (state_q == FS_RDLO);
        idle_o      = (state_q == FS_IDLE);
        save_req_o  = (state_q == FS_SAVE);
        mem_rd_o    = (state_q == FS_RDHI) || lo_sel;
        mem_addr_o  = ADDR_W'({src_q, lo_sel});
        vec_valid_o = (state_q == FS_DONE);
        vec_addr_o  = vec_q;
        vec_src_o   = src_q;
    end
endmodule

// File: rtl/vic_core.sv
module vic_core
    import vic_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter int CTL_W  = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NSRC-1:0]     src_i,
    input  logic                ctl_we,
    input  logic [1:0]          ctl_addr,
    input  logic [CTL_W-1:0]    ctl_wdata,
    input  logic                ack_i,
    input  logic                save_done_i,
    input  logic                halt_i,
    output logic                irq_o,
    output logic                wake_o,
    output logic                save_req_o,
    output logic                mem_rd_o,
    output logic [ADDR_W-1:0]   mem_addr_o,
    input  logic [DATA_W-1:0]   mem_rdata_i,
    output logic                vec_valid_o,
    output logic [2*DATA_W-1:0] vec_addr_o,
    output logic [SRC_W-1:0]    vec_src_o,
    output logic [NSRC-1:0]     mask_o,
    output logic [NSRC-1:0]     pend_o,
    output logic [SRC_W-1:0]    prio_o,
    output logic                gie_o
);
    logic [NSRC-1:0]  mask_q;
    logic [SRC_W-1:0] prio_q;
    logic             gie_q;
    logic [NSRC-1:0]  pend;
    logic [NSRC-1:0]  enabled;
    logic             any_en;
    logic             idle;
    logic             win_hit;
    logic [SRC_W-1:0] win_idx;
    logic             grant;
    logic             wr_mask, wr_pend, wr_prio, wr_gie;
    logic             unused_wdata;

    assign unused_wdata = ^ctl_wdata[CTL_W-1:NSRC];

    always_comb begin
        wr_mask = ctl_we && (ctl_addr == CA_MASK);
        wr_pend = ctl_we && (ctl_addr == CA_PEND);
        wr_prio = ctl_we && (ctl_addr == CA_PRIO);
        wr_gie  = ctl_we && (ctl_addr == CA_GIE);
        enabled = pend & mask_q;
        any_en  = |enabled;
        irq_o   = idle && gie_q && any_en && win_hit;
        grant   = irq_o && ack_i;
        wake_o  = halt_i && gie_q && any_en;
    end

    vic_pending u_pend (
        .clk     (clk),
        .rst     (rst),
        .src_i   (src_i),
        .wr_en   (wr_pend),
        .wr_val  (ctl_wdata[NSRC-1:0]),
        .clr_en  (grant),
        .clr_idx (win_idx),
        .pend_o  (pend)
    );

    vic_arbiter u_arb (
        .req_i  (enabled),
        .code_i (prio_q),
        .hit_o  (win_hit),
        .idx_o  (win_idx)
    );

    vic_fetch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fetch (
        .clk         (clk),
        .rst         (rst),
        .grant_i     (grant),
        .grant_idx_i (win_idx),
        .save_done_i (save_done_i),
        .idle_o      (idle),
        .save_req_o  (save_req_o),
        .mem_rd_o    (mem_rd_o),
        .mem_addr_o  (mem_addr_o),
        .mem_rdata_i (mem_rdata_i),
        .vec_valid_o (vec_valid_o),
        .vec_addr_o  (vec_addr_o),
        .vec_src_o   (vec_src_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
            prio_q <= '0;
            gie_q  <= 1'b0;
        end else begin
            if (wr_mask) mask_q <= ctl_wdata[NSRC-1:0];
            if (wr_prio) prio_q <= ctl_wdata[SRC_W-1:0];
            if (grant)       gie_q <= 1'b0;
            else if (wr_gie) gie_q <= ctl_wdata[0];
        end
    end

    assign mask_o = mask_q;
    assign pend_o = pend;
    assign prio_o = prio_q;
    assign gie_o  = gie_q;
endmodule

// File: rtl/vic_core_chk.sv
module vic_core_chk
    import vic_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              ack_i,
    input logic              halt_i,
    input logic              irq_o,
    input logic              wake_o,
    input logic              save_req_o,
    input logic              mem_rd_o,
    input logic [ADDR_W-1:0] mem_addr_o,
    input logic              vec_valid_o,
    input logic [SRC_W-1:0]  vec_src_o,
    input logic [NSRC-1:0]   mask_o,
    input logic [NSRC-1:0]   pend_o,
    input logic              gie_o
);
    a_r3_irq_needs_gie: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> gie_o);

    a_r3_irq_needs_pend: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> (|(pend_o & mask_o)));

    a_r5_gie_drop: assert property (@(posedge clk) disable iff (rst)
        (irq_o && ack_i) |=> !gie_o);

    a_r5_save_follows: assert property (@(posedge clk) disable iff (rst)
        (irq_o && ack_i) |=> save_req_o);

    a_r10_save_needs_grant: assert property (@(posedge clk) disable iff (rst)
        $rose(save_req_o) |-> $past(irq_o && ack_i));

    a_r6_lo_after_hi: assert property (@(posedge clk) disable iff (rst)
        (mem_rd_o && !mem_addr_o[0]) |=> (mem_rd_o && mem_addr_o == $past(mem_addr_o) + 1'b1));

    a_r6_addr_range: assert property (@(posedge clk) disable iff (rst)
        mem_rd_o |-> (int'(mem_addr_o) < 2 * NSRC));

    a_r7_single_pulse: assert property (@(posedge clk) disable iff (rst)
        vec_valid_o |=> !vec_valid_o);

    a_r7_src_range: assert property (@(posedge clk) disable iff (rst)
        vec_valid_o |-> (int'(vec_src_o) < NSRC));

    a_r8_busy_no_irq: assert property (@(posedge clk) disable iff (rst)
        save_req_o |-> !irq_o);

    a_r9_wake_needs_halt: assert property (@(posedge clk) disable iff (rst)
        wake_o |-> (halt_i && gie_o));
endmodule

bind vic_core vic_core_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .ack_i       (ack_i),
    .halt_i      (halt_i),
    .irq_o       (irq_o),
    .wake_o      (wake_o),
    .save_req_o  (save_req_o),
    .mem_rd_o    (mem_rd_o),
    .mem_addr_o  (mem_addr_o),
    .vec_valid_o (vec_valid_o),
    .vec_src_o   (vec_src_o),
    .mask_o      (mask_o),
    .pend_o      (pend_o),
    .gie_o       (gie_o)
);

// File: tb/vic_core_tb_top.sv
`timescale 1ns/1ps
module vic_core_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [5:0]  src_i = '0;
    logic        ctl_we = 1'b0;
    logic [1:0]  ctl_addr = '0;
    logic [7:0]  ctl_wdata = '0;
    logic        ack_i = 1'b0;
    logic        save_done_i = 1'b0;
    logic        halt_i = 1'b0;
    logic        irq_o, wake_o, save_req_o, mem_rd_o, vec_valid_o, gie_o;
    logic [7:0]  mem_addr_o;
    logic [7:0]  mem_rdata_i = '0;
    logic [15:0] vec_addr_o;
    logic [2:0]  vec_src_o, prio_o;
    logic [5:0]  mask_o, pend_o;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    vic_core dut_i (
        .clk(clk), .rst(rst), .src_i(src_i), .ctl_we(ctl_we), .ctl_addr(ctl_addr),
        .ctl_wdata(ctl_wdata), .ack_i(ack_i), .save_done_i(save_done_i), .halt_i(halt_i),
        .irq_o(irq_o), .wake_o(wake_o), .save_req_o(save_req_o), .mem_rd_o(mem_rd_o),
        .mem_addr_o(mem_addr_o), .mem_rdata_i(mem_rdata_i), .vec_valid_o(vec_valid_o),
        .vec_addr_o(vec_addr_o), .vec_src_o(vec_src_o), .mask_o(mask_o), .pend_o(pend_o),
        .prio_o(prio_o), .gie_o(gie_o)
    );

    function automatic logic [7:0] mem_byte(input int a);
        return 8'((a * 29 + 7) & 255);
    endfunction

    always @(posedge clk) if (mem_rd_o) mem_rdata_i <= mem_byte(int'(mem_addr_o));

    // Reference model state
    bit [5:0] m_pend, m_mask, m_srcq;
    int       m_prio, m_st, m_src;
    bit       m_gie;

    function automatic int ref_win(input bit [5:0] req, input int code);
        int start;
        start = (code < 6) ? code : 0;
        for (int k = 0; k < 6; k++) begin
            if (req[(start + k) % 6]) return (start + k) % 6;
        end
        return -1;
    endfunction

    always @(posedge clk) begin
        bit [5:0] rise;
        bit       req_now, grant;
        int       w;
        if (rst) begin
            m_pend = '0; m_mask = '0; m_srcq = '0; m_prio = 0; m_gie = 0; m_st = 0; m_src = 0;
        end else begin
            rise    = src_i & ~m_srcq;
            m_srcq  = src_i;
            req_now = (m_st == 0) && m_gie && ((m_pend & m_mask) != 0);
            grant   = req_now && ack_i;
            w       = ref_win(m_pend & m_mask, m_prio);
            if (ctl_we && ctl_addr == 2'd1) m_pend = ctl_wdata[5:0];
            if (grant) m_pend[w] = 1'b0;
            m_pend = m_pend | rise;
            if (ctl_we && ctl_addr == 2'd0) m_mask = ctl_wdata[5:0];
            if (ctl_we && ctl_addr == 2'd2) m_prio = int'(ctl_wdata[2:0]);
            if (grant) m_gie = 1'b0;
            else if (ctl_we && ctl_addr == 2'd3) m_gie = ctl_wdata[0];
            case (m_st)
                0: if (grant) begin m_st = 1; m_src = w; end
                1: if (save_done_i) m_st = 2;
                5: m_st = 0;
                default: m_st = m_st + 1;
            endcase
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    task automatic compare();
        bit e_irq, e_wake;
        int e_vec;
        e_irq  = (m_st == 0) && m_gie && ((m_pend & m_mask) != 0);
        e_wake = halt_i && m_gie && ((m_pend & m_mask) != 0);
        check(irq_o == e_irq, "R3 irq_o", int'(irq_o), int'(e_irq));
        check(wake_o == e_wake, "R9 wake_o", int'(wake_o), int'(e_wake));
        check(pend_o == m_pend, "R2 pend_o", int'(pend_o), int'(m_pend));
        check(mask_o == m_mask && int'(prio_o) == m_prio, "R4 mask/prio",
              int'({mask_o, prio_o}), (int'(m_mask) << 3) | m_prio);
        check(gie_o == m_gie, "R5 gie_o", int'(gie_o), int'(m_gie));
        check(save_req_o == (m_st == 1), "R5 save_req_o", int'(save_req_o), int'(m_st == 1));
        check(mem_rd_o == (m_st == 2 || m_st == 3), "R6 mem_rd_o", int'(mem_rd_o),
              int'(m_st == 2 || m_st == 3));
        if (m_st == 2 || m_st == 3)
            check(int'(mem_addr_o) == 2 * m_src + (m_st == 3 ? 1 : 0), "R6 mem_addr_o",
                  int'(mem_addr_o), 2 * m_src + (m_st == 3 ? 1 : 0));
        check(vec_valid_o == (m_st == 5), "R7 vec_valid_o", int'(vec_valid_o), int'(m_st == 5));
        if (m_st == 5) begin
            e_vec = (int'(mem_byte(2 * m_src)) << 8) | int'(mem_byte(2 * m_src + 1));
            check(int'(vec_addr_o) == e_vec && int'(vec_src_o) == m_src, "R7 vector",
                  int'({vec_src_o, vec_addr_o}), (m_src << 16) | e_vec);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
        compare();
    endtask

    task automatic wr(input int a, input int d);
        ctl_we = 1'b1; ctl_addr = 2'(a); ctl_wdata = 8'(d);
        cyc();
        ctl_we = 1'b0;
    endtask

    task automatic pulse(input int n);
        src_i[n] = 1'b1; cyc();
        src_i[n] = 1'b0; cyc();
    endtask

    task automatic run_grant(output int got, output int got_vec);
        got = -1; got_vec = -1;
        for (int i = 0; i < 20 && !irq_o; i++) cyc();
        ack_i = 1'b1; cyc(); ack_i = 1'b0;
        cyc();
        save_done_i = 1'b1; cyc(); save_done_i = 1'b0;
        for (int i = 0; i < 10; i++) begin
            cyc();
            if (vec_valid_o) begin
                got = int'(vec_src_o);
                got_vec = int'(vec_addr_o);
                break;
            end
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            errors++;
            $display("FAIL watchdog expired actual=%0d expected<20000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int got, gv;
        int codes[4] = '{0, 3, 5, 7};
        int wins[4]  = '{0, 3, 5, 0};

        repeat (3) cyc();
        rst = 1'b0;
        // R1 reset state
        check(pend_o == 0 && mask_o == 0 && prio_o == 0 && !gie_o && !irq_o && !save_req_o
              && !mem_rd_o && !vec_valid_o, "R1 reset state", int'({pend_o, mask_o}), 0);

        // Basic grant of source 4 (R5, R6, R7)
        wr(0, 8'h3F); wr(3, 1);
        pulse(4);
        check(irq_o == 1'b1, "R3 irq after enabled edge", int'(irq_o), 1);
        run_grant(got, gv);
        check(got == 4, "R7 winner source", got, 4);
        check(gv == ((int'(mem_byte(8)) << 8) | int'(mem_byte(9))), "R7 handler address", gv,
              (int'(mem_byte(8)) << 8) | int'(mem_byte(9)));
        check(!gie_o && pend_o[4] == 1'b0, "R5 enable and pending cleared",
              int'({gie_o, pend_o[4]}), 0);

        // Edge and pending write collide (R2)
        ctl_we = 1'b1; ctl_addr = 2'd1; ctl_wdata = 8'h00; src_i[5] = 1'b1;
        cyc();
        ctl_we = 1'b0; src_i[5] = 1'b0;
        cyc();
        check(pend_o == 6'h20, "R2 edge wins over write", int'(pend_o), 'h20);
        wr(1, 0);

        // Mask blocks a request (R3)
        wr(0, 8'h3E); wr(3, 1);
        pulse(0);
        check(pend_o[0] && !irq_o, "R3 masked source no irq", int'({pend_o[0], irq_o}), 2);
        wr(0, 8'h3F);
        check(irq_o == 1'b1, "R3 unmasked source irq", int'(irq_o), 1);
        run_grant(got, gv);
        check(got == 0, "R3 unmasked winner", got, 0);

        // Priority rotations (R4)
        foreach (codes[i]) begin
            wr(1, 8'h3F); wr(2, codes[i]); wr(3, 1);
            run_grant(got, gv);
            check(got == wins[i], "R4 priority winner", got, wins[i]);
            check(int'(pend_o) == (6'h3F & ~(1 << wins[i])), "R5 only winner cleared",
                  int'(pend_o), 6'h3F & ~(1 << wins[i]));
        end
        wr(1, 0); wr(2, 0);

        // Held-high line triggers once (R2)
        wr(3, 1);
        src_i[2] = 1'b1; cyc(); cyc();
        run_grant(got, gv);
        check(got == 2, "R2 held line winner", got, 2);
        repeat (3) cyc();
        check(pend_o[2] == 1'b0, "R2 held line no retrigger", int'(pend_o[2]), 0);
        src_i[2] = 1'b0; cyc();

        // Request during save latches (R8)
        wr(1, 8'h01); wr(3, 1);
        ack_i = 1'b1; cyc(); ack_i = 1'b0;
        src_i[1] = 1'b1; cyc(); src_i[1] = 1'b0; cyc();
        check(pend_o[1] && !irq_o && save_req_o, "R8 latched during save",
              int'({pend_o[1], irq_o, save_req_o}), 5);
        save_done_i = 1'b1; cyc(); save_done_i = 1'b0;
        repeat (6) cyc();
        wr(3, 1);
        run_grant(got, gv);
        check(got == 1, "R8 deferred request served", got, 1);

        // Halt and wake (R9)
        halt_i = 1'b1;
        pulse(3);
        check(pend_o[3] && !wake_o, "R9 latch while halted, enable off",
              int'({pend_o[3], wake_o}), 2);
        wr(3, 1);
        check(wake_o == 1'b1, "R9 wake with enable", int'(wake_o), 1);
        halt_i = 1'b0; cyc();
        check(!wake_o && irq_o, "R9 wake drops when running", int'({wake_o, irq_o}), 1);
        run_grant(got, gv);
        check(got == 3, "R9 wake source served", got, 3);

        // Ack ignored without irq (R10)
        wr(3, 0); wr(1, 8'h04);
        ack_i = 1'b1; cyc(); ack_i = 1'b0; cyc();
        check(!save_req_o && pend_o == 6'h04, "R10 stray ack ignored",
              int'({save_req_o, pend_o}), 'h04);

        repeat (4) cyc();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule